// File: doc/BRIEF.md
# Double-Buffered Operand Streaming Unit

This block sits between memory and an arithmetic pipeline so that neither side waits on the other. Two input double buffers, X and Y, deliver operand pairs to the arithmetic unit. An output double buffer, Z, gathers results and returns them to memory. Every half of each double buffer holds one octet, which is eight elements. Within a double buffer, one half is loaded from memory or drained to memory while the other half serves the arithmetic side. Each half changes role when its octet is complete.

Memory pushes elements into X or Y through a single fill port. A steering bit chooses the buffer. The arithmetic unit takes operand pairs through a valid/ready handshake and returns results through a second handshake. Z presents completed octets on a write-back stream.

When a later operand depends on results still held in Z, the requester raises a forward request and names X or Y as the destination. The octet waiting in Z is then copied whole into the loading half of that buffer in one cycle, with no trip through memory.

Top module: `opstream_unit`

## Requirements
- R1: After reset, op_valid and wb_valid are 0, in_ready and res_ready are 1, and fwd_ready is 0.
- R2: op_valid is 1 only while both X and Y have a complete octet ready to serve. Filling X alone, with Y empty, keeps op_valid at 0.
- R3: Operand pairs leave in the order their elements entered. Pair k carries the k-th element accepted into X (on op_x) and the k-th element accepted into Y (on op_y). Forwarded octets count as accepted elements in Z order.
- R4: Each input buffer holds at most two octets that have not been consumed. When both halves of the buffer chosen by in_sel (0 = X, 1 = Y) are full, in_ready is 0.
- R5: Results reach the write-back stream in arrival order. wb_valid rises only when eight results complete an octet, in the cycle after the eighth result is accepted.
- R6: When both Z halves hold octets not yet written back, res_ready is 0. It returns to 1 once a half has been drained.
- R7: A forward raised while the oldest Z octet is complete and none of it has been written back copies all eight elements into the destination. That octet never appears on the write-back stream.
- R8: A forward raised after write-back of the oldest Z octet has begun still copies all eight elements, and the remaining elements of that octet are still written back.
- R9: fwd_ready is 0 when the destination's loading half is full or partly filled, and when Z holds no complete octet.
- R10: While fwd_req is 1, wb_valid and in_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Memory element available |
| in_sel | input | 1 | Destination of the memory element: 0 = X, 1 = Y |
| in_data | input | DW | Memory element |
| in_ready | output | 1 | Selected input buffer can take the element |
| op_valid | output | 1 | Operand pair available |
| op_ready | input | 1 | Arithmetic unit takes the pair |
| op_x | output | DW | X operand |
| op_y | output | DW | Y operand |
| res_valid | input | 1 | Result available from the arithmetic unit |
| res_data | input | DW | Result value |
| res_ready | output | 1 | Z can take a result |
| wb_valid | output | 1 | Result element available for memory |
| wb_ready | input | 1 | Memory takes the element |
| wb_data | output | DW | Element written back |
| fwd_req | input | 1 | Request to copy the oldest Z octet into X or Y |
| fwd_dst | input | 1 | Forward destination: 0 = X, 1 = Y |
| fwd_ready | output | 1 | Forward to fwd_dst would be taken this cycle |

## Verification
A corrupted half-full flag or pointer shows up as an operand pair or write-back element that disagrees with the scoreboard. It appears at the first handshake that reads the bad half, which is at most eight transfers after the fault. A lost or stuck flag instead shows up as a ready or valid level that is wrong at the next cycle boundary. A forward that fails to release Z, or releases it wrongly, shows up as extra or missing write-back elements. Those are detected when the stream is drained at the end of the scenario.

// File: rtl/osu_pkg.sv
package osu_pkg;
  typedef enum logic {SEL_X = 1'b0, SEL_Y = 1'b1} osu_sel_e;

  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/osu_pingpong.sv
module osu_pingpong #(
  parameter int DW  = 16,
  parameter int OCT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ok,
  input  logic              fwd_en,
  input  logic [OCT*DW-1:0] fwd_data,
  output logic              fwd_ok,
  input  logic              rd_en,
  output logic              rd_ok,
  output logic [DW-1:0]     rd_data
);
  localparam int IW = osu_pkg::idx_width(OCT);
  localparam logic [IW-1:0] LAST = IW'(OCT - 1);

  logic [DW-1:0] mem [2][OCT];
  logic [1:0]    full;
  logic          fh, rh;
  logic [IW-1:0] fidx, ridx;

  // storage: no reset, written by fill or by whole-octet copy
  always_ff @(posedge clk) begin
    if (fwd_en) begin
      for (int i = 0; i < OCT; i++) mem[fh][i] <= fwd_data[i*DW +: DW];
    end else if (wr_en) begin
      mem[fh][fidx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= '0; fh <= 1'b0; rh <= 1'b0; fidx <= '0; ridx <= '0;
    end else begin
      if (fwd_en) begin
        full[fh] <= 1'b1;
        fh       <= ~fh;
      end else if (wr_en) begin
        if (fidx == LAST) begin
          fidx     <= '0;
          full[fh] <= 1'b1;
          fh       <= ~fh;
        end else begin
          fidx <= fidx + 1'b1;
        end
      end
      if (rd_en) begin
        if (ridx == LAST) begin
          ridx     <= '0;
          full[rh] <= 1'b0;
          rh       <= ~rh;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
    end
  end

  assign wr_ok   = !full[fh];
  assign fwd_ok  = !full[fh] && (fidx == '0);
  assign rd_ok   = full[rh];
  assign rd_data = mem[rh][ridx];

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en || fwd_en) |-> !full[fh]);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> full[rh]);
  a_r9_copy_into_clean_half: assert property (@(posedge clk) disable iff (rst)
    fwd_en |-> (fidx == '0) && !wr_en);
endmodule

// File: rtl/osu_resbuf.sv
module osu_resbuf #(
  parameter int DW  = 16,
  parameter int OCT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_en,
  input  logic [DW-1:0]     res_data,
  output logic              res_ok,
  input  logic              wb_en,
  output logic              wb_ok,
  output logic [DW-1:0]     wb_data,
  input  logic              fwd_en,
  output logic              fwd_avail,
  output logic [OCT*DW-1:0] fwd_data
);
  localparam int IW = osu_pkg::idx_width(OCT);
  localparam logic [IW-1:0] LAST = IW'(OCT - 1);

  logic [DW-1:0] mem [2][OCT];
  logic [1:0]    zfull;
  logic          zw, zd;
  logic [IW-1:0] widx, didx;

  always_ff @(posedge clk) begin
    if (res_en) mem[zw][widx] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zfull <= '0; zw <= 1'b0; zd <= 1'b0; widx <= '0; didx <= '0;
    end else begin
      if (res_en) begin
        if (widx == LAST) begin
          widx      <= '0;
          zfull[zw] <= 1'b1;
          zw        <= ~zw;
        end else begin
          widx <= widx + 1'b1;
        end
      end
      if (fwd_en && didx == '0) begin
        zfull[zd] <= 1'b0;              // copied, nothing left to write
        zd        <= ~zd;
      end else if (wb_en) begin
        if (didx == LAST) begin
          didx      <= '0;
          zfull[zd] <= 1'b0;
          zd        <= ~zd;
        end else begin
          didx <= didx + 1'b1;
        end
      end
    end
  end

  assign res_ok    = !zfull[zw];
  assign wb_ok     = zfull[zd];
  assign wb_data   = mem[zd][didx];
  assign fwd_avail = zfull[zd];

  for (genvar g = 0; g < OCT; g++) begin : g_flat
    assign fwd_data[g*DW +: DW] = mem[zd][g];
  end

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
    res_en |-> !zfull[zw]);
  a_r7_release_on_copy: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && didx == '0) |=> zd != $past(zd));
  a_r8_keep_draining: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && didx != '0) |=> $stable(zd) && zfull[zd]);
endmodule

// File: rtl/opstream_unit.sv
module opstream_unit #(
  parameter int DW  = 16,
  parameter int OCT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sel,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [DW-1:0] op_x,
  output logic [DW-1:0] op_y,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [DW-1:0] wb_data,
  input  logic          fwd_req,
  input  logic          fwd_dst,
  output logic          fwd_ready
);
  import osu_pkg::*;

  localparam int NB = 2;   // input buffers: X and Y

  logic [OCT*DW-1:0] z_oct;
  logic              z_avail, z_wb_ok;
  logic              fwd_go, rd_go;
  logic [NB-1:0]     wr_ok, fwd_ok, rd_ok;
  logic [DW-1:0]     rd_data [NB];

  assign rd_go = op_valid && op_ready;

  for (genvar b = 0; b < NB; b++) begin : g_in
    osu_pingpong #(.DW(DW), .OCT(OCT)) u_buf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (in_valid && in_ready && (in_sel == b[0])),
      .wr_data  (in_data),
      .wr_ok    (wr_ok[b]),
      .fwd_en   (fwd_go && (fwd_dst == b[0])),
      .fwd_data (z_oct),
      .fwd_ok   (fwd_ok[b]),
      .rd_en    (rd_go),
      .rd_ok    (rd_ok[b]),
      .rd_data  (rd_data[b])
    );
  end

  osu_resbuf #(.DW(DW), .OCT(OCT)) u_z (
    .clk       (clk),
    .rst       (rst),
    .res_en    (res_valid && res_ready),
    .res_data  (res_data),
    .res_ok    (res_ready),
    .wb_en     (wb_valid && wb_ready),
    .wb_ok     (z_wb_ok),
    .wb_data   (wb_data),
    .fwd_en    (fwd_go),
    .fwd_avail (z_avail),
    .fwd_data  (z_oct)
  );

  assign fwd_ready = z_avail && fwd_ok[fwd_dst];
  assign fwd_go    = fwd_req && fwd_ready;
  assign in_ready  = wr_ok[in_sel] && !fwd_req;
  assign wb_valid  = z_wb_ok && !fwd_req;
  assign op_valid  = rd_ok[SEL_X] && rd_ok[SEL_Y];
  assign op_x      = rd_data[SEL_X];
  assign op_y      = rd_data[SEL_Y];

  a_r5_wb_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready && !fwd_req) |=> (wb_valid || fwd_req) && $stable(wb_data));
  a_r2_op_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready && !fwd_req) |=> op_valid && $stable(op_x) && $stable(op_y));
  a_r10_no_wb_during_fwd: assert property (@(posedge clk) disable iff (rst)
    fwd_req |-> !wb_valid && !in_ready);
endmodule

// File: tb/tb_opstream_unit.sv
module tb_opstream_unit;
  localparam int DW  = 16;
  localparam int OCT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sel = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, op_valid, res_ready, wb_valid, fwd_ready;
  logic op_ready = 1'b0, res_valid = 1'b0, wb_ready = 1'b0;
  logic fwd_req = 1'b0, fwd_dst = 1'b0;
  logic [DW-1:0] op_x, op_y, wb_data;
  logic [DW-1:0] res_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] qx[$], qy[$], qwb[$];
  int wb_seen = 0;

  always #10 clk = ~clk;

  opstream_unit #(.DW(DW), .OCT(OCT)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compares handshakes that complete at the coming edge
  always @(negedge clk) begin
    if (!rst && op_valid && op_ready) begin
      if (qx.size() == 0 || qy.size() == 0) check("R3 unexpected pair", 1, 0);
      else begin
        check("R3 op_x", op_x, qx.pop_front());
        check("R3 op_y", op_y, qy.pop_front());
      end
    end
    if (!rst && wb_valid && wb_ready) begin
      wb_seen++;
      if (qwb.size() == 0) check("R7 unexpected write-back", wb_data, 0);
      else check("R5 wb_data", wb_data, qwb.pop_front());
    end
  end

  // drivers: all change at posedge + 1
  task automatic put_in(input logic sel, input logic [DW-1:0] d);
    in_valid = 1'b1; in_sel = sel; in_data = d;
    if (sel) qy.push_back(d); else qx.push_back(d);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic put_res(input logic [DW-1:0] d, input bit to_mem);
    res_valid = 1'b1; res_data = d;
    if (to_mem) qwb.push_back(d);
    do @(negedge clk); while (!res_ready);
    @(posedge clk); #1 res_valid = 1'b0;
  endtask

  task automatic drain_ops();
    op_ready = 1'b1;
    while (qx.size() != 0 || qy.size() != 0) @(negedge clk);
    @(posedge clk); #1 op_ready = 1'b0;
  endtask

  task automatic forward(input logic dst, input logic [DW-1:0] base);
    fwd_req = 1'b1; fwd_dst = dst;
    @(negedge clk);
    check("R7 fwd_ready", fwd_ready, 1);
    check("R10 wb_valid during fwd", wb_valid, 0);
    check("R10 in_ready during fwd", in_ready, 0);
    for (int i = 0; i < OCT; i++)
      if (dst) qy.push_back(base + DW'(i)); else qx.push_back(base + DW'(i));
    @(posedge clk); #1 fwd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 op_valid", op_valid, 0);
    check("R1 wb_valid", wb_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 res_ready", res_ready, 1);
    check("R1 fwd_ready", fwd_ready, 0);
    @(posedge clk); #1;

    // R2: X alone never issues
    for (int i = 0; i < OCT; i++) put_in(1'b0, DW'(16'h100 + i));
    @(negedge clk); check("R2 op_valid with X only", op_valid, 0);
    @(posedge clk); #1;
    for (int i = 0; i < OCT; i++) put_in(1'b1, DW'(16'h200 + i));
    @(negedge clk); check("R2 op_valid both full", op_valid, 1);
    @(posedge clk); #1;
    drain_ops();
    @(negedge clk); check("R2 op_valid after drain", op_valid, 0);
    @(posedge clk); #1;

    // R4: two octets ahead, then full
    for (int i = 0; i < 2*OCT; i++) put_in(1'b0, DW'(16'h300 + i));
    in_valid = 1'b0; in_sel = 1'b0;
    @(negedge clk); check("R4 in_ready X full", in_ready, 0);
    @(posedge clk); #1 in_sel = 1'b1;
    @(negedge clk); check("R4 in_ready Y free", in_ready, 1);
    @(posedge clk); #1;
    for (int i = 0; i < 2*OCT; i++) put_in(1'b1, DW'(16'h400 + i));
    drain_ops();
    check("R3 all pairs consumed", qx.size() + qy.size(), 0);

    // R5/R6: write-back octets
    for (int i = 0; i < OCT-1; i++) put_res(DW'(16'h500 + i), 1'b1);
    @(negedge clk); check("R5 wb_valid after 7", wb_valid, 0);
    @(posedge clk); #1;
    put_res(DW'(16'h507), 1'b1);
    @(negedge clk); check("R5 wb_valid after 8", wb_valid, 1);
    @(posedge clk); #1;
    for (int i = 0; i < OCT; i++) put_res(DW'(16'h508 + i), 1'b1);
    @(negedge clk); check("R6 res_ready both halves full", res_ready, 0);
    @(posedge clk); #1 wb_ready = 1'b1;
    while (qwb.size() != 0) @(negedge clk);
    @(posedge clk); #1 wb_ready = 1'b0;
    @(negedge clk); check("R6 res_ready after drain", res_ready, 1);
    check("R5 octets written", wb_seen, 2*OCT);
    @(posedge clk); #1;

    // R7: forward before write-back starts
    for (int i = 0; i < OCT; i++) put_res(DW'(16'h600 + i), 1'b0);
    forward(1'b0, DW'(16'h600));
    wb_ready = 1'b1;
    @(negedge clk); check("R7 wb_valid after release", wb_valid, 0);
    @(posedge clk); #1;
    for (int i = 0; i < OCT; i++) put_in(1'b1, DW'(16'h700 + i));
    drain_ops();
    wb_ready = 1'b0;

    // R8: forward after write-back begins
    for (int i = 0; i < OCT; i++) put_res(DW'(16'h800 + i), 1'b1);
    wb_ready = 1'b1;
    repeat (3) begin
      do @(negedge clk); while (!wb_valid);
      @(posedge clk);
    end
    #1 wb_ready = 1'b0;
    forward(1'b1, DW'(16'h800));
    @(negedge clk); check("R8 wb_valid still pending", wb_valid, 1);
    @(posedge clk); #1;
    for (int i = 0; i < OCT; i++) put_in(1'b0, DW'(16'h900 + i));
    drain_ops();
    wb_ready = 1'b1;
    while (qwb.size() != 0) @(negedge clk);
    @(posedge clk); #1 wb_ready = 1'b0;
    check("R8 remaining elements written", wb_seen, 3*OCT);

    // R9: partly filled destination blocks forwarding
    for (int i = 0; i < OCT; i++) put_res(DW'(16'hA00 + i), 1'b0);
    for (int i = 0; i < 3; i++) put_in(1'b0, DW'(16'hB00 + i));
    fwd_dst = 1'b0;
    @(negedge clk); check("R9 fwd_ready X partial", fwd_ready, 0);
    @(posedge clk); #1 fwd_dst = 1'b1;
    @(negedge clk); check("R9 fwd_ready Y empty", fwd_ready, 1);
    @(posedge clk); #1;
    forward(1'b1, DW'(16'hA00));
    for (int i = 3; i < OCT; i++) put_in(1'b0, DW'(16'hB00 + i));
    drain_ops();
    wb_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 no write-back of copied octet", wb_seen, 3*OCT);
    check("R9 fwd_ready no Z octet", fwd_ready, 0);
    summary();
  end
endmodule